// File: doc/BRIEF.md
# Logarithmic-Domain Multiply, Divide, Root and Square Unit

This unit does arithmetic on numbers held in logarithmic form. Each word has a sign bit on top and a signed base-2 logarithm of the magnitude below it. The log field is 19 bits wide, two's complement, with 8 fractional bits, so the whole word is 20 bits. In this form the costly linear operations become cheap ones on the log field. A product adds the logs. A quotient subtracts them. A square root is a one-place arithmetic right shift, and squaring is a one-place left shift. Every result passes through one saturating stage, so a result that leaves the log range clamps to its nearest end and raises an overflow flag.

Exact zero has no logarithm, so it gets a reserved code: sign 0 with the most negative log value (20'h40000). A zero operand gives a zero result. Division by zero and the root of a negative value give zero and raise their own flags. Operands come in through a valid/ready handshake. The result is held in a single output slot that a two-state controller runs. The controller states are EMPTY and FULL. Its transitions are ACCEPT (EMPTY to FULL when an operation is taken), DRAIN (FULL to EMPTY when the result is consumed and nothing new is taken), REPLACE (FULL stays FULL when the result is consumed and a new operation is taken in the same cycle) and STALL (FULL stays FULL while the consumer is not ready).

Top module: `lns_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid` is 0.
- R2: `in_ready` is high when the slot is empty or `out_ready` is high. An operation taken at a clock edge appears with `out_valid` high right after that edge, one cycle of latency. A result that is not consumed stays unchanged.
- R3: Opcode 0 (multiply) returns the sum of the two log fields, with sign = sign(a) XOR sign(b).
- R4: Opcode 1 (divide) returns log(a) minus log(b), with sign = sign(a) XOR sign(b).
- R5: Opcode 2 (square root) returns log(a) arithmetically shifted right by one, which rounds toward minus infinity, with sign 0.
- R6: Opcode 3 (square) returns log(a) shifted left by one, and the result keeps the sign of a.
- R7: A word whose log field is 19'h40000 is zero, whatever its sign. A multiply with any zero operand returns zero. A divide with a zero dividend and a nonzero divisor returns zero. A root or square of zero returns zero. A zero result is always 20'h40000 with `out_zero` set.
- R8: Divide with a zero divisor returns the zero word with both `out_dz` and `out_zero` set.
- R9: Square root of a nonzero operand with sign 1 returns the zero word with both `out_inv` and `out_zero` set.
- R10: A log result above 262143 clamps to 262143, and one below -262143 clamps to -262143. In either case `out_ovf` is set. The zero code is never produced by clamping.
- R11: For square root and square, operand b has no effect on the result or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present on the inputs |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_op | input | 2 | 0 multiply, 1 divide, 2 square root, 3 square |
| in_a | input | 20 | First operand: sign at bit 19, log at bits 18:0 |
| in_b | input | 20 | Second operand, same layout |
| out_valid | output | 1 | Result slot holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_word | output | 20 | Result word |
| out_zero | output | 1 | Result is exact zero |
| out_ovf | output | 1 | Log result was clamped |
| out_inv | output | 1 | Root of a negative operand |
| out_dz | output | 1 | Division by zero |

## Verification
The bench goes after the following corner cases.
- Square roots of negative odd logs. A shift that rounds toward zero would be off by one there.
- Sums and differences just past either end of the log range. A missing clamp would wrap the sign, and a clamp to the full minimum would emit the zero code.
- Zero operands paired with negative signs, and a zero divisor. Checking the operand sign before the zero test would raise a false invalid flag or a false zero result.
- Backpressure, including REPLACE cycles. A slot that loses or repeats a result shows up as a mismatch against the cycle-by-cycle model.

// File: rtl/lns_pkg.sv
package lns_pkg;

    typedef enum logic [1:0] {
        OP_MUL    = 2'd0,
        OP_DIV    = 2'd1,
        OP_SQRT   = 2'd2,
        OP_SQUARE = 2'd3
    } lns_op_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } slot_state_e;

    typedef struct packed {
        logic dz;
        logic inv;
        logic ovf;
        logic zero;
    } lns_flags_t;

endpackage

// File: rtl/lns_opdecode.sv
module lns_opdecode #(
    parameter int LOG_W = 19
) (
    input  logic [LOG_W:0]          word_i,
    output logic                    sign_o,
    output logic signed [LOG_W-1:0] log_o,
    output logic                    zero_o
);
    localparam logic [LOG_W-1:0] ZERO_LOG = {1'b1, {(LOG_W-1){1'b0}}};

    assign sign_o = word_i[LOG_W];
    assign log_o  = word_i[LOG_W-1:0];
    assign zero_o = (word_i[LOG_W-1:0] == ZERO_LOG);
endmodule

// File: rtl/lns_saturate.sv
module lns_saturate #(
    parameter int LOG_W = 19
) (
    input  logic signed [LOG_W+1:0] raw_i,
    output logic [LOG_W-1:0]        log_o,
    output logic                    ovf_o
);
    localparam logic signed [LOG_W+1:0] HI = {3'b000, {(LOG_W-1){1'b1}}};
    localparam logic signed [LOG_W+1:0] LO = -HI;

    always_comb begin
        if (raw_i > HI) begin
            log_o = HI[LOG_W-1:0];
            ovf_o = 1'b1;
        end else if (raw_i < LO) begin
            log_o = LO[LOG_W-1:0];
            ovf_o = 1'b1;
        end else begin
            log_o = raw_i[LOG_W-1:0];
            ovf_o = 1'b0;
        end
    end
endmodule

// File: rtl/lns_core.sv
module lns_core
    import lns_pkg::*;
#(
    parameter int LOG_W = 19
) (
    input  lns_op_e          op_i,
    input  logic [LOG_W:0]   a_i,
    input  logic [LOG_W:0]   b_i,
    output logic [LOG_W:0]   word_o,
    output lns_flags_t       flags_o
);
    localparam int NOPS = 2;
    localparam logic [LOG_W:0] ZERO_WORD = {2'b01, {(LOG_W-1){1'b0}}};

    logic [LOG_W:0]          opw [NOPS];
    logic                    sgn [NOPS];
    logic signed [LOG_W-1:0] lg  [NOPS];
    logic                    zr  [NOPS];

    assign opw[0] = a_i;
    assign opw[1] = b_i;

    for (genvar g = 0; g < NOPS; g++) begin : g_dec
        lns_opdecode #(.LOG_W(LOG_W)) u_dec (
            .word_i (opw[g]),
            .sign_o (sgn[g]),
            .log_o  (lg[g]),
            .zero_o (zr[g])
        );
    end

    logic signed [LOG_W+1:0] ea, eb, raw;
    logic [LOG_W-1:0]        sat_log;
    logic                    sat_ovf;

    assign ea = {{2{lg[0][LOG_W-1]}}, lg[0]};
    assign eb = {{2{lg[1][LOG_W-1]}}, lg[1]};

    always_comb begin
        unique case (op_i)
            OP_MUL:    raw = ea + eb;
            OP_DIV:    raw = ea - eb;
            OP_SQRT:   raw = ea >>> 1;
            OP_SQUARE: raw = ea <<< 1;
            default:   raw = ea;
        endcase
    end

    lns_saturate #(.LOG_W(LOG_W)) u_sat (
        .raw_i (raw),
        .log_o (sat_log),
        .ovf_o (sat_ovf)
    );

    always_comb begin
        flags_o = '0;
        word_o  = ZERO_WORD;
        unique case (op_i)
            OP_MUL: begin
                if (zr[0] || zr[1]) begin
                    flags_o.zero = 1'b1;
                end else begin
                    word_o      = {sgn[0] ^ sgn[1], sat_log};
                    flags_o.ovf = sat_ovf;
                end
            end
            OP_DIV: begin
                if (zr[1]) begin
                    flags_o.dz   = 1'b1;
                    flags_o.zero = 1'b1;
                end else if (zr[0]) begin
                    flags_o.zero = 1'b1;
                end else begin
                    word_o      = {sgn[0] ^ sgn[1], sat_log};
                    flags_o.ovf = sat_ovf;
                end
            end
            OP_SQRT: begin
                if (zr[0]) begin
                    flags_o.zero = 1'b1;
                end else if (sgn[0]) begin
                    flags_o.inv  = 1'b1;
                    flags_o.zero = 1'b1;
                end else begin
                    word_o      = {1'b0, sat_log};
                    flags_o.ovf = sat_ovf;
                end
            end
            OP_SQUARE: begin
                if (zr[0]) begin
                    flags_o.zero = 1'b1;
                end else begin
                    word_o      = {sgn[0], sat_log};
                    flags_o.ovf = sat_ovf;
                end
            end
            default: begin
                flags_o.zero = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/lns_unit.sv
module lns_unit
    import lns_pkg::*;
#(
    parameter int LOG_W = 19,
    localparam int WORD_W = LOG_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_op,
    input  logic [WORD_W-1:0] in_a,
    input  logic [WORD_W-1:0] in_b,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word,
    output logic              out_zero,
    output logic              out_ovf,
    output logic              out_inv,
    output logic              out_dz
);
    localparam logic [WORD_W-1:0] ZERO_WORD = {2'b01, {(LOG_W-1){1'b0}}};
    localparam logic [LOG_W-1:0]  LOG_HI    = {1'b0, {(LOG_W-1){1'b1}}};
    localparam logic [LOG_W-1:0]  LOG_LO    = {1'b1, {(LOG_W-2){1'b0}}, 1'b1};

    slot_state_e       state_q, state_d;
    logic [WORD_W-1:0] word_q, core_word;
    lns_flags_t        flags_q, core_flags;
    logic              take;

    lns_core #(.LOG_W(LOG_W)) u_core (
        .op_i    (lns_op_e'(in_op)),
        .a_i     (in_a),
        .b_i     (in_b),
        .word_o  (core_word),
        .flags_o (core_flags)
    );

    assign in_ready = (state_q == ST_EMPTY) || out_ready;
    assign take     = in_valid && in_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (take) state_d = ST_FULL;
            ST_FULL:  if (out_ready && !take) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q  <= ZERO_WORD;
            flags_q <= '0;
        end else if (take) begin
            word_q  <= core_word;
            flags_q <= core_flags;
        end
    end

    assign out_valid = (state_q == ST_FULL);
    assign out_word  = word_q;
    assign out_zero  = flags_q.zero;
    assign out_ovf   = flags_q.ovf;
    assign out_inv   = flags_q.inv;
    assign out_dz    = flags_q.dz;

    a_r1_empty_after_reset: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    a_r2_accept_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    a_r2_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(flags_q)));

    a_r7_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_zero) |-> (out_word == ZERO_WORD));

    a_r8_dz_gives_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_dz) |-> (out_zero && !out_ovf && !out_inv));

    a_r9_inv_gives_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_inv) |-> (out_zero && !out_dz));

    a_r10_clamp_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ovf) |->
            (!out_zero && (out_word[LOG_W-1:0] == LOG_HI || out_word[LOG_W-1:0] == LOG_LO)));
endmodule

// File: tb/lns_unit_test.sv
module lns_unit_test;
    localparam int MAXL = (1 << 18) - 1;
    localparam int MINL = -(1 << 18);
    localparam bit [19:0] ZW = 20'h40000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, out_ready = 1'b0;
    logic [1:0] in_op = 2'd0;
    logic [19:0] in_a = '0, in_b = '0;
    logic in_ready, out_valid, out_zero, out_ovf, out_inv, out_dz;
    logic [19:0] out_word;

    int checks = 0;
    int errors = 0;
    bit exp_valid = 1'b0;
    bit [23:0] exp_v = '0;
    string exp_tag = "R2";

    always #2 clk = ~clk;

    lns_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_ready(out_ready), .out_word(out_word), .out_zero(out_zero),
        .out_ovf(out_ovf), .out_inv(out_inv), .out_dz(out_dz)
    );

    function automatic bit [19:0] w(bit s, int l);
        bit [31:0] u = l;
        return {s, u[18:0]};
    endfunction

    // returns {dz, inv, ovf, zero, word}
    function automatic bit [23:0] ref_op(bit [1:0] op, bit [19:0] a, bit [19:0] b);
        int la = int'($signed(a[18:0]));
        int lb = int'($signed(b[18:0]));
        bit za = (la == MINL);
        bit zb = (lb == MINL);
        int r = 0;
        bit s = 1'b0;
        bit ovf = 1'b0;
        bit [31:0] ru;
        case (op)
            2'd0: begin
                if (za || zb) return {4'b0001, ZW};
                r = la + lb; s = a[19] ^ b[19];
            end
            2'd1: begin
                if (zb) return {4'b1001, ZW};
                if (za) return {4'b0001, ZW};
                r = la - lb; s = a[19] ^ b[19];
            end
            2'd2: begin
                if (za) return {4'b0001, ZW};
                if (a[19]) return {4'b0101, ZW};
                r = la >>> 1; s = 1'b0;
            end
            default: begin
                if (za) return {4'b0001, ZW};
                r = la * 2; s = a[19];
            end
        endcase
        if (r > MAXL) begin r = MAXL; ovf = 1'b1; end
        else if (r < MINL + 1) begin r = MINL + 1; ovf = 1'b1; end
        ru = r;
        return {2'b00, ovf, 1'b0, s, ru[18:0]};
    endfunction

    task automatic check(bit ok, string tag, string what, bit [23:0] act, bit [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic cycle(bit v, bit [1:0] op, bit [19:0] a, bit [19:0] b, bit rdy, string tag);
        bit acc;
        @(negedge clk);
        in_valid = v; in_op = op; in_a = a; in_b = b; out_ready = rdy;
        #1;
        check(in_ready == (!exp_valid || rdy), "R2", "in_ready",
              {23'd0, in_ready}, {23'd0, (!exp_valid || rdy)});
        @(posedge clk);
        acc = v && (!exp_valid || rdy);
        if (acc) begin
            exp_valid = 1'b1;
            exp_v = ref_op(op, a, b);
            exp_tag = tag;
        end else if (rdy) begin
            exp_valid = 1'b0;
        end
        #1;
        check(out_valid == exp_valid, "R2", "out_valid",
              {23'd0, out_valid}, {23'd0, exp_valid});
        if (exp_valid)
            check({out_dz, out_inv, out_ovf, out_zero, out_word} == exp_v, exp_tag, "result",
                  {out_dz, out_inv, out_ovf, out_zero, out_word}, exp_v);
    endtask

    task automatic op1(bit [1:0] op, bit [19:0] a, bit [19:0] b, string tag);
        cycle(1'b1, op, a, b, 1'b1, tag);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL R2 watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R1", "out_valid in reset", {23'd0, out_valid}, 24'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(out_valid == 1'b0, "R1", "out_valid after reset", {23'd0, out_valid}, 24'd0);

        // R3: 8*4 -> log 3.0 + 2.0 = 5.0, signs combine by XOR
        op1(2'd0, w(0, 768), w(0, 512), "R3");
        op1(2'd0, w(1, 768), w(0, -300), "R3");
        op1(2'd0, w(1, -5), w(1, 17), "R3");
        // R4: 8/4 -> 3.0 - 2.0 = 1.0
        op1(2'd1, w(0, 768), w(0, 512), "R4");
        op1(2'd1, w(1, -1000), w(0, 2000), "R4");
        // R5: sqrt 16 -> 4.0 -> 2.0; negative odd log rounds toward minus infinity
        op1(2'd2, w(0, 1024), w(0, 0), "R5");
        op1(2'd2, w(0, -3), w(0, 0), "R5");
        op1(2'd2, w(0, MINL + 1), w(0, 0), "R5");
        // R6: square keeps sign of a
        op1(2'd3, w(0, 768), w(0, 0), "R6");
        op1(2'd3, w(1, -77), w(0, 0), "R6");
        // R7: zero operands, either sign on the zero
        op1(2'd0, w(1, MINL), w(0, 512), "R7");
        op1(2'd0, w(0, 512), w(1, MINL), "R7");
        op1(2'd1, w(1, MINL), w(0, 99), "R7");
        op1(2'd2, w(1, MINL), w(0, 0), "R7");
        op1(2'd3, w(1, MINL), w(0, 0), "R7");
        // R8: zero divisor, also with zero dividend
        op1(2'd1, w(0, 256), w(1, MINL), "R8");
        op1(2'd1, w(0, MINL), w(0, MINL), "R8");
        // R9: root of negative
        op1(2'd2, w(1, 256), w(0, 0), "R9");
        // R10: clamp at both ends
        op1(2'd0, w(0, MAXL), w(0, 1), "R10");
        op1(2'd0, w(0, MINL + 1), w(0, -1), "R10");
        op1(2'd1, w(0, -200000), w(0, 200000), "R10");
        op1(2'd3, w(0, 140000), w(0, 0), "R10");
        op1(2'd3, w(1, -140000), w(0, 0), "R10");
        op1(2'd0, w(0, MAXL), w(0, 0), "R10");
        // R11: b has no effect on root and square
        op1(2'd2, w(0, 1000), w(1, MINL), "R11");
        op1(2'd2, w(0, 1000), w(1, 12345), "R11");
        op1(2'd3, w(1, 1000), w(1, MINL), "R11");
        op1(2'd3, w(1, 1000), w(0, -9), "R11");
        // R2: backpressure, stall then replace and drain
        cycle(1'b1, 2'd0, w(0, 10), w(0, 20), 1'b0, "R2");
        cycle(1'b1, 2'd0, w(0, 30), w(0, 40), 1'b0, "R2");
        cycle(1'b1, 2'd1, w(0, 30), w(0, 40), 1'b0, "R2");
        cycle(1'b1, 2'd1, w(0, 50), w(0, 7), 1'b1, "R2");
        cycle(1'b0, 2'd0, w(0, 0), w(0, 0), 1'b0, "R2");
        cycle(1'b0, 2'd0, w(0, 0), w(0, 0), 1'b1, "R2");
        cycle(1'b0, 2'd0, w(0, 0), w(0, 0), 1'b1, "R2");

        // mixed sweep with random handshake and extreme operands
        for (int i = 0; i < 600; i++) begin
            bit [19:0] a = $urandom;
            bit [19:0] b = $urandom;
            bit [3:0] k = 4'($urandom);
            if (k == 0) a[18:0] = 19'h40000;
            if (k == 1) b[18:0] = 19'h40000;
            if (k == 2) a[18:0] = 19'h3FFFF;
            if (k == 3) b[18:0] = 19'h40001;
            cycle(1'($urandom), 2'($urandom), a, b, 1'($urandom), "R2");
        end
        cycle(1'b0, 2'd0, '0, '0, 1'b1, "R2");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule